// File: doc/BRIEF.md
# Write-Only Two-Wire Control Decoder for a Four-Source Video Switch

This block is a write-only slave on a two-wire serial control bus (I2C). A local system clock oversamples the clock and data lines, and the block detects START and STOP conditions. It checks the incoming device address and acknowledges accepted bytes by pulling the data line low. The first byte after the address selects a register. Each later byte in the same transfer is stored at that register and then at the ones after it, with the pointer stepping by one for each byte.

Only control register 0 is decoded. Its bits drive a 2-bit source select for a matrix that routes one of four video sources: the internal tuner path or one of three external inputs. The same select steers both the composite/luma path and the chroma path. Two more bits of register 0 drive a global enable and a monitor-buffer enable. Bytes aimed at register positions that have no storage are acknowledged and then dropped.

The block has no streaming data interface. The bus lines and the decoded controls are plain level signals. The slave never stretches the clock, never answers a read, and has no data path that could apply back-pressure.

Top module: `i2c_switch_ctrl`

## Requirements
- R1: After reset, src_sel_o is 2'b00, chan_en_o is 0, buf_en_o is 0, and sda_pull_o is 0.
- R2: Only the address byte 0x94 is acknowledged. This is the 7-bit address 0x4A followed by a write bit of 0. Any other address, and the same address with the read bit set to 1, gets no acknowledge, and the slave waits for the next START.
- R3: After an acknowledged address, the next byte is taken as the register pointer and the bytes after it as data, and the slave acknowledges each of them.
- R4: Each data byte goes to the current pointer, and the pointer then steps by one. The pointer is 8 bits wide, so 0xFF is followed by 0x00.
- R5: src_sel_o equals bits 1:0 of register 0. The code 00 selects the internal source, and 01, 10 and 11 select external inputs 1, 2 and 3.
- R6: chan_en_o equals bit 7 of register 0. A value of 0 puts every channel in standby.
- R7: buf_en_o equals bit 6 of register 0 while bit 7 is 1, and is 0 whenever bit 7 is 0.
- R8: A data byte sent to any pointer value of NUM_REGS or more is acknowledged and changes no output.
- R9: A STOP received at any point returns the slave to idle. A START received after one or more bits of a byte aborts the transfer, and the slave ignores the bus until the next START. Neither event writes a register.
- R10: A register value changes the outputs only on the SCL falling edge at which the slave starts to acknowledge that data byte. Before that edge the outputs keep their old value.
- R11: The slave changes sda_pull_o only while SCL is low, and releases the line on the SCL falling edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| src_sel_o | output | 2 | Video source select for luma and chroma paths |
| chan_en_o | output | 1 | Global channel enable (0 = standby) |
| buf_en_o | output | 1 | Monitor buffer enable |

## Verification
The bench uses the default parameters: device address 0x4A, one implemented register, and two synchronizer stages. With only one live register, every pointer value other than 0x00 falls in the discard range. A two-byte burst that starts at 0xFF therefore shows both the pointer wrap and the discard path through the outputs alone. With two synchronizer stages and 30 clocks per quarter bit, the bench can take output snapshots just before and just after the acknowledge edge and tell them apart.

// File: rtl/i2c_sw_pkg.sv
package i2c_sw_pkg;

  localparam int BYTE_W = 8;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK
  } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_sw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              start_o,
  output logic              stop_o,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);

  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [BITCNT_W-1:0] FULL  = BITCNT_W'(BYTE_W);

  slv_state_t          state_q;
  logic [BITCNT_W-1:0] bitcnt_q;
  logic [BYTE_W-1:0]   shreg_q;
  logic [BYTE_W-1:0]   ptr_q;
  logic                rx_state;
  logic                mid_byte;
  logic                byte_done;

  assign start_o   = scl_lvl_i & sda_fall_i;
  assign stop_o    = scl_lvl_i & sda_rise_i;
  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) ||
                     (state_q == ST_DATA);
  assign mid_byte  = rx_state && (bitcnt_q != '0);
  assign byte_done = (bitcnt_q == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_o) begin
        state_q    <= ST_IDLE;
        bitcnt_q   <= '0;
        sda_pull_o <= 1'b0;
      end else if (start_o) begin
        bitcnt_q   <= '0;
        sda_pull_o <= 1'b0;
        state_q    <= mid_byte ? ST_IDLE : ST_ADDR;
      end else if (scl_rise_i) begin
        if (rx_state && !byte_done) begin
          shreg_q  <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end else if (scl_fall_i) begin
        case (state_q)
          ST_ADDR: begin
            if (byte_done) begin
              if (shreg_q == ADDR_WR) begin
                state_q    <= ST_ADDR_ACK;
                sda_pull_o <= 1'b1;
              end else begin
                state_q  <= ST_IDLE;
                bitcnt_q <= '0;
              end
            end
          end
          ST_SUB: begin
            if (byte_done) begin
              ptr_q      <= shreg_q;
              state_q    <= ST_SUB_ACK;
              sda_pull_o <= 1'b1;
            end
          end
          ST_DATA: begin
            if (byte_done) begin
              wr_en_o    <= 1'b1;
              wr_addr_o  <= ptr_q;
              wr_data_o  <= shreg_q;
              ptr_q      <= ptr_q + 1'b1;
              state_q    <= ST_DATA_ACK;
              sda_pull_o <= 1'b1;
            end
          end
          ST_ADDR_ACK: begin
            sda_pull_o <= 1'b0;
            bitcnt_q   <= '0;
            state_q    <= ST_SUB;
          end
          ST_SUB_ACK, ST_DATA_ACK: begin
            sda_pull_o <= 1'b0;
            bitcnt_q   <= '0;
            state_q    <= ST_DATA;
          end
          default: begin
            state_q <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sw_reg_file.sv
module sw_reg_file
  import i2c_sw_pkg::*;
#(
  parameter int NUM_REGS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] ctrl_word_o
);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs_q[gi] <= '0;
        else if (wr_en_i && (wr_addr_i == BYTE_W'(gi)))
          regs_q[gi] <= wr_data_i;
      end
    end
  endgenerate

  assign ctrl_word_o = regs_q[0];

endmodule

// File: rtl/sw_ctrl_decode.sv
module sw_ctrl_decode #(
  parameter int SEL_W = 2
) (
  input  logic             std_bit_i,
  input  logic             buf_bit_i,
  input  logic [SEL_W-1:0] sel_bits_i,
  output logic [SEL_W-1:0] src_sel_o,
  output logic             chan_en_o,
  output logic             buf_en_o
);

  assign src_sel_o = sel_bits_i;
  assign chan_en_o = std_bit_i;
  assign buf_en_o  = std_bit_i & buf_bit_i;

endmodule

// File: rtl/i2c_switch_ctrl.sv
module i2c_switch_ctrl
  import i2c_sw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4A,
  parameter int         NUM_REGS    = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [1:0] src_sel_o,
  output logic       chan_en_o,
  output logic       buf_en_o
);

  localparam int NLINES  = 2;
  localparam int SEL_W   = 2;
  localparam int STD_BIT = 7;
  localparam int BUF_BIT = 6;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] lvl;
  logic [NLINES-1:0] rise;
  logic [NLINES-1:0] fall;

  logic              scl_q;
  logic              start_q;
  logic              stop_q;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] ctrl_word;
  logic              unused_fill_bits;

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar gl = 0; gl < NLINES; gl++) begin : g_sync
      i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (raw_lines[gl]),
        .level_o (lvl[gl]),
        .rise_o  (rise[gl]),
        .fall_o  (fall[gl])
      );
    end
  endgenerate

  assign scl_q = lvl[0];

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (lvl[0]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_lvl_i  (lvl[1]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .start_o    (start_q),
    .stop_o     (stop_q),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  sw_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .ctrl_word_o (ctrl_word)
  );

  sw_ctrl_decode #(.SEL_W(SEL_W)) u_decode (
    .std_bit_i  (ctrl_word[STD_BIT]),
    .buf_bit_i  (ctrl_word[BUF_BIT]),
    .sel_bits_i (ctrl_word[SEL_W-1:0]),
    .src_sel_o  (src_sel_o),
    .chan_en_o  (chan_en_o),
    .buf_en_o   (buf_en_o)
  );

  assign unused_fill_bits = ^ctrl_word[BUF_BIT-1:SEL_W];

endmodule

// File: rtl/i2c_switch_ctrl_chk.sv
module i2c_switch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       start_q,
  input logic       stop_q,
  input logic       sda_pull_o,
  input logic [1:0] src_sel_o,
  input logic       chan_en_o,
  input logic       buf_en_o
);

  // R7: the monitor buffer is never enabled while the channels are in standby
  assert_buf_in_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en_o |-> !buf_en_o);

  // R10: outputs move only one cycle after the acknowledge pull has started
  assert_update_at_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_sel_o != $past(src_sel_o)) || (chan_en_o != $past(chan_en_o)) ||
     (buf_en_o != $past(buf_en_o)))
    |-> (sda_pull_o && $past(sda_pull_o) && !$past(sda_pull_o, 2)));

  // R11: the pull changes only with SCL low, or when a START/STOP releases it
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_q) || $past(start_q) || $past(stop_q)));

  // R9: a STOP always leaves the data line released
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !sda_pull_o);

endmodule

bind i2c_switch_ctrl i2c_switch_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_q      (scl_q),
  .start_q    (start_q),
  .stop_q     (stop_q),
  .sda_pull_o (sda_pull_o),
  .src_sel_o  (src_sel_o),
  .chan_en_o  (chan_en_o),
  .buf_en_o   (buf_en_o)
);

// File: tb/test_i2c_switch_ctrl.sv
`timescale 1ns/1ps
module test_i2c_switch_ctrl;

  localparam int Q = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_bus;
  logic       sda_pull;
  logic [1:0] src_sel;
  logic       chan_en;
  logic       buf_en;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model_reg0 = 8'h00;

  logic [1:0] pre_sel;
  logic       pre_chan;
  logic [1:0] post_sel;
  logic       post_chan;

  always #4 clk = ~clk;

  assign sda_bus = sda_drv & ~sda_pull;

  i2c_switch_ctrl i_i2c_switch_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .src_sel_o  (src_sel),
    .chan_en_o  (chan_en),
    .buf_en_o   (buf_en)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [7:0] r);
    return r[1:0];
  endfunction
  function automatic logic exp_chan(input logic [7:0] r);
    return r[7];
  endfunction
  function automatic logic exp_buf(input logic [7:0] r);
    return r[7] & r[6];
  endfunction

  task automatic check_outputs(input string tag);
    chk(src_sel == exp_sel(model_reg0), "R5", {tag, " src_sel"}, int'(src_sel), int'(exp_sel(model_reg0)));
    chk(chan_en == exp_chan(model_reg0), "R6", {tag, " chan_en"}, int'(chan_en), int'(exp_chan(model_reg0)));
    chk(buf_en == exp_buf(model_reg0), "R7", {tag, " buf_en"}, int'(buf_en), int'(exp_buf(model_reg0)));
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b, input bit last);
    sda_drv = b; tick(Q);
    scl = 1'b1;  tick(Q);
    if (last) begin
      pre_sel  = src_sel;
      pre_chan = chan_en;
    end
    tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i], i == 0);
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    acked     = (sda_bus == 1'b0);
    post_sel  = src_sel;
    post_chan = chan_en;
    tick(Q);
    scl = 1'b0;     tick(Q);
    // R11: line released after the acknowledge clock
    chk(sda_bus == 1'b1, "R11", "release after ack clock", int'(sda_bus), 1);
  endtask

  task automatic xfer(input logic [7:0] ab, input logic [7:0] sub,
                      input logic [7:0] d0, input logic [7:0] d1,
                      input int n, input string tag);
    bit a;
    logic [7:0] ptr;
    bus_start();
    send_byte(ab, a);
    chk(a == (ab == 8'h94), "R2", {tag, " address ack"}, int'(a), int'(ab == 8'h94));
    if (a) begin
      send_byte(sub, a);
      chk(a, "R3", {tag, " pointer ack"}, int'(a), 1);
      ptr = sub;
      for (int k = 0; k < n; k++) begin
        logic [7:0] d;
        d = (k == 0) ? d0 : d1;
        send_byte(d, a);
        chk(a, (ptr == 8'h00) ? "R3" : "R8", {tag, " data ack"}, int'(a), 1);
        if (ptr == 8'h00) model_reg0 = d;
        ptr = ptr + 8'h01;
      end
    end
    bus_stop();
    tick(4);
    check_outputs(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'h5EED_1234));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    chk(src_sel == 2'b00, "R1", "reset src_sel", int'(src_sel), 0);
    chk(chan_en == 1'b0, "R1", "reset chan_en", int'(chan_en), 0);
    chk(buf_en == 1'b0, "R1", "reset buf_en", int'(buf_en), 0);
    chk(sda_pull == 1'b0, "R1", "reset sda_pull", int'(sda_pull), 0);

    // R5 R6 R7: full active, input 3
    xfer(8'h94, 8'h00, 8'hFF, 8'h00, 1, "active_in3");
    // R7: standby forces buffer off even with bit 6 set
    xfer(8'h94, 8'h00, 8'h7D, 8'h00, 1, "standby_buf");
    // R6 R7: active, buffer off, input 1
    xfer(8'h94, 8'h00, 8'hBD, 8'h00, 1, "active_nobuf_in1");

    // R2: wrong address and read direction are not acknowledged
    xfer(8'h96, 8'h00, 8'h00, 8'h00, 0, "wrong_addr");
    xfer(8'h95, 8'h00, 8'h00, 8'h00, 0, "read_bit");

    // R4 R8: pointer wraps 0xFF -> 0x00; first byte discarded
    xfer(8'h94, 8'hFF, 8'h11, 8'hFE, 2, "wrap_R4");
    // R4 R8: second byte goes to 0x01 and is discarded
    xfer(8'h94, 8'h00, 8'hC2, 8'h3F, 2, "incr_R4");
    // R8: unimplemented pointer
    xfer(8'h94, 8'h05, 8'h00, 8'h00, 1, "unimpl_R8");

    // R10: outputs old before the ack edge, new at the ack clock
    bus_start();
    send_byte(8'h94, a);
    send_byte(8'h00, a);
    send_byte(8'h7C, a);
    chk(pre_sel == 2'b10 && pre_chan == 1'b1, "R10", "value before ack edge",
        int'({pre_chan, pre_sel}), 3'b110);
    chk(post_sel == 2'b00 && post_chan == 1'b0, "R10", "value at ack clock",
        int'({post_chan, post_sel}), 3'b000);
    model_reg0 = 8'h7C;
    bus_stop();
    tick(4);
    check_outputs("R10 after");

    // R9: STOP after part of a data byte writes nothing
    bus_start();
    send_byte(8'h94, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    tick(4);
    check_outputs("R9 stop mid-byte");

    // R9: START after three bits aborts; the next address byte is ignored
    bus_start();
    send_byte(8'h94, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    bus_start();
    send_byte(8'h94, a);
    chk(!a, "R9", "address after aborting start", int'(a), 0);
    send_byte(8'hFF, a);
    chk(!a, "R9", "no ack while ignoring", int'(a), 0);
    bus_stop();
    tick(4);
    check_outputs("R9 start mid-byte");

    // random mix
    for (int t = 0; t < 12; t++) begin
      logic [7:0] ab;
      logic [7:0] sub;
      int r;
      r = int'($urandom % 6);
      ab = (r == 0) ? 8'h95 : ((r == 1) ? 8'h14 : 8'h94);
      r = int'($urandom % 3);
      sub = (r == 0) ? 8'h00 : ((r == 1) ? 8'hFF : 8'($urandom));
      xfer(ab, sub, 8'($urandom), 8'($urandom), 1 + int'($urandom % 2), "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule